// File: doc/BRIEF.md
# External Bus Turnaround Idle-State Inserter

This block runs external bus accesses for a CPU-side request port and, where a bus turnaround could let two devices drive the data bus at once, it puts one dead bus state in front of the new access. Every access walks three bus states, T1, T2 and T3, one clock each. The optional dead state, Ti, comes before T1 of the new access. In Ti both strobes are off and the data driver is disabled, but the address bus already carries the new address.

Two rules can ask for the dead state, and each has its own enable bit in a small configuration register. Both bits are set by reset. The area rule fires when a read comes straight after a read to a different area, where the area is the top address bits. The write rule fires when a write comes straight after a read. An access that follows a write never gets the dead state. If the block spends a cycle idle with no request waiting, it forgets that the last access was a read.

A request is held on `req_valid` until it is taken on a clock edge where `req_ready` is high. The block raises `rsp_done` for one clock once T3 is over. For a read, `rsp_rdata` carries the value sampled from `bus_din` at the end of T3.

Top module: `bus_idle_gap`

## Requirements
- R1: After reset, `req_ready` is 1 and `bus_rd`, `bus_wr`, `bus_oe` and `rsp_done` are 0. Both rules are enabled until software writes the configuration.
- R2: A read with no dead state drives `bus_rd` for the three clocks that follow the accepting edge. `rsp_done` is high in the fourth clock, and `rsp_rdata` then equals the `bus_din` value presented for the address during T3.
- R3: A write drives `bus_oe` in T1, T2 and T3 and drives `bus_wr` in T2 and T3 only, with `bus_dout` equal to the request's write data. `bus_rd` is never high at the same time as `bus_oe` or `bus_wr`.
- R4: The area is address bits [ADDR_W-1 : ADDR_W-AREA_W]. With the area rule enabled, a read taken in the idle cycle right after the done of a read to another area gets one dead state, so its done comes in the fifth clock after the accepting edge.
- R5: A read right after a read to the same area never gets a dead state.
- R6: With the write rule enabled, a write taken right after the done of a read gets one dead state.
- R7: A read or write that follows a write never gets a dead state.
- R8: Writing 0 to a rule's enable bit (`cfg_we` high, with `cfg_area_gap` for the area rule and `cfg_wr_gap` for the write rule) stops that rule from adding a dead state.
- R9: During the dead state all strobes and `bus_oe` are 0 and `bus_addr` already equals the new request's address. The address stays stable through the access.
- R10: If a clock edge passes with the block idle and `req_valid` low, the next access gets no dead state, even if the last access was a read.
- R11: `req_ready` is high only while no access is in progress, and that includes the clock in which `rsp_done` is high. `rsp_done` is one clock wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the two rule-enable bits |
| cfg_area_gap | input | 1 | New value of the area-rule enable |
| cfg_wr_gap | input | 1 | New value of the write-rule enable |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Access address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block is idle and takes a request on this edge |
| rsp_done | output | 1 | One-clock pulse after T3 |
| rsp_rdata | output | DATA_W | Read data of the last read |
| bus_addr | output | ADDR_W | External address bus |
| bus_dout | output | DATA_W | External data bus output value |
| bus_oe | output | 1 | Data bus output enable |
| bus_rd | output | 1 | Read strobe, active high |
| bus_wr | output | 1 | Write strobe, active high |
| bus_din | input | DATA_W | External data bus input value |

## Verification
The bench builds the block with ADDR_W=12, DATA_W=8 and AREA_W=3, so all eight areas can be reached with short addresses and read data can be derived arithmetically from the address. For each of the four settings of the enable bits and each of the four read/write orderings, it sweeps every pair of first and second area: 1024 back-to-back pairs, each preceded by an idle spacer cycle. This covers every combination of rule, area match and history clearing, and checks the dead state, the strobe placement, the done timing and the read data of each access.

// File: rtl/bus_gap_pkg.sv
package bus_gap_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_TI   = 3'd1,
        ST_T1   = 3'd2,
        ST_T2   = 3'd3,
        ST_T3   = 3'd4
    } bus_state_t;

    typedef struct packed {
        logic area;
        logic wr;
    } gap_enables_t;

    // Decide whether a new access needs a dead bus state before T1.
    function automatic logic gap_needed(
        input logic         last_was_read,
        input logic         other_area,
        input logic         new_is_write,
        input gap_enables_t en
    );
        logic by_area;
        logic by_write;
        by_area  = en.area && !new_is_write && other_area;
        by_write = en.wr && new_is_write;
        return last_was_read && (by_area || by_write);
    endfunction

endpackage

// File: rtl/bus_gap_hist.sv
module bus_gap_hist
    import bus_gap_pkg::*;
#(
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              end_cycle,
    input  logic              cur_is_read,
    input  logic [AREA_W-1:0] cur_area,
    input  logic              idle_empty,
    input  logic              new_write,
    input  logic [AREA_W-1:0] new_area,
    input  gap_enables_t      en,
    output logic              need_gap
);

    logic              last_rd;
    logic [AREA_W-1:0] last_area;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_rd   <= 1'b0;
            last_area <= '0;
        end else if (end_cycle) begin
            last_rd   <= cur_is_read;
            last_area <= cur_area;
        end else if (idle_empty) begin
            last_rd   <= 1'b0;
        end
    end

    always_comb begin
        need_gap = gap_needed(last_rd, (new_area != last_area), new_write, en);
    end

endmodule

// File: rtl/bus_gap_seq.sv
module bus_gap_seq
    import bus_gap_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              need_gap,
    input  logic [DATA_W-1:0] bus_din,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic              end_cycle,
    output logic              idle_empty,
    output logic              cur_write
);

    bus_state_t        state;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_wdata;
    logic              cap_write;
    logic              in_access;

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cap_addr  <= '0;
            cap_wdata <= '0;
            cap_write <= 1'b0;
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        cap_addr  <= req_addr;
                        cap_wdata <= req_wdata;
                        cap_write <= req_write;
                        state     <= need_gap ? ST_TI : ST_T1;
                    end
                end
                ST_TI: state <= ST_T1;
                ST_T1: state <= ST_T2;
                ST_T2: state <= ST_T3;
                ST_T3: begin
                    if (!cap_write) begin
                        rsp_rdata <= bus_din;
                    end
                    rsp_done <= 1'b1;
                    state    <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        in_access  = (state == ST_T1) || (state == ST_T2) || (state == ST_T3);
        req_ready  = (state == ST_IDLE);
        end_cycle  = (state == ST_T3);
        idle_empty = (state == ST_IDLE) && !req_valid;
        bus_rd     = in_access && !cap_write;
        bus_oe     = in_access && cap_write;
        bus_wr     = cap_write && ((state == ST_T2) || (state == ST_T3));
        bus_addr   = cap_addr;
        bus_dout   = cap_wdata;
        cur_write  = cap_write;
    end

endmodule

// File: rtl/bus_idle_gap.sv
module bus_idle_gap
    import bus_gap_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int AREA_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic              cfg_area_gap,
    input  logic              cfg_wr_gap,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic [DATA_W-1:0] bus_din
);

    localparam int AREA_LSB = ADDR_W - AREA_W;

    gap_enables_t en;
    logic         need_gap;
    logic         end_cycle;
    logic         idle_empty;
    logic         cur_write;

    always_ff @(posedge clk) begin
        if (rst) begin
            en <= '{area: 1'b1, wr: 1'b1};
        end else if (cfg_we) begin
            en <= '{area: cfg_area_gap, wr: cfg_wr_gap};
        end
    end

    bus_gap_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .need_gap   (need_gap),
        .bus_din    (bus_din),
        .req_ready  (req_ready),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata),
        .bus_addr   (bus_addr),
        .bus_dout   (bus_dout),
        .bus_oe     (bus_oe),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .end_cycle  (end_cycle),
        .idle_empty (idle_empty),
        .cur_write  (cur_write)
    );

    bus_gap_hist #(.AREA_W(AREA_W)) u_hist (
        .clk         (clk),
        .rst         (rst),
        .end_cycle   (end_cycle),
        .cur_is_read (!cur_write),
        .cur_area    (bus_addr[ADDR_W-1:AREA_LSB]),
        .idle_empty  (idle_empty),
        .new_write   (req_write),
        .new_area    (req_addr[ADDR_W-1:AREA_LSB]),
        .en          (en),
        .need_gap    (need_gap)
    );

endmodule

// File: rtl/bus_idle_gap_chk.sv
module bus_idle_gap_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_oe,
    input logic              bus_rd,
    input logic              bus_wr
);

    assert_rd_oe_apart_R3: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && (bus_oe || bus_wr)));

    assert_wr_needs_oe_R3: assert property (@(posedge clk) disable iff (rst)
        bus_wr |-> bus_oe);

    assert_wr_after_oe_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_wr) |-> $past(bus_oe));

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    assert_ready_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !(bus_rd || bus_wr || bus_oe));

    assert_done_after_access_R2: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(bus_rd || bus_oe));

    assert_addr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_oe) && $past(bus_rd || bus_oe)) |-> $stable(bus_addr));

endmodule

bind bus_idle_gap bus_idle_gap_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_addr  (bus_addr),
    .bus_oe    (bus_oe),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr)
);

// File: tb/bus_idle_gap_test.sv
module bus_idle_gap_test;

    localparam int AW = 12;
    localparam int DW = 8;
    localparam int ARW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0, cfg_area_gap = 1'b0, cfg_wr_gap = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done, bus_oe, bus_rd, bus_wr;
    logic [DW-1:0] rsp_rdata, bus_dout, bus_din;
    logic [AW-1:0] bus_addr;

    int total = 0;
    int bad = 0;
    bit last_rd = 0;
    bit en_a = 1, en_w = 1;

    always #4 clk = ~clk;

    function automatic logic [DW-1:0] mem_of(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    assign bus_din = mem_of(bus_addr);

    bus_idle_gap #(.ADDR_W(AW), .DATA_W(DW), .AREA_W(ARW)) uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_area_gap(cfg_area_gap),
        .cfg_wr_gap(cfg_wr_gap), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .bus_addr(bus_addr),
        .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_din(bus_din)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge where done is seen.
    task automatic access(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit gap, input string tag);
        int n;
        bit wr_seen;
        chk(req_ready == 1'b1, "R11 ready before request", req_ready, 1);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (gap) begin
            chk({bus_rd, bus_wr, bus_oe} == 3'b000, "R9 strobes off in dead state",
                {bus_rd, bus_wr, bus_oe}, 0);
            chk(bus_addr == a, "R9 address in dead state", bus_addr, a);
        end else begin
            chk({bus_rd, bus_wr, bus_oe} == {!w, 1'b0, w}, {tag, " T1 strobes"},
                {bus_rd, bus_wr, bus_oe}, {!w, 1'b0, w});
        end
        n = 1;
        wr_seen = 0;
        while (!rsp_done && n < 8) begin
            chk(req_ready == 1'b0, "R11 busy during access", req_ready, 0);
            if (w && bus_wr && bus_oe && bus_dout == d && n == (gap ? 3 : 2)) wr_seen = 1;
            @(negedge clk);
            n++;
        end
        chk(n == (gap ? 5 : 4), {tag, " done timing"}, n, gap ? 5 : 4);
        if (w) chk(wr_seen, "R3 write strobe and data", wr_seen, 1);
        else   chk(rsp_rdata == mem_of(a), "R2 read data", rsp_rdata, mem_of(a));
        chk(req_ready == 1'b1, "R11 ready in done clock", req_ready, 1);
        last_rd = !w;
    endtask

    task automatic set_cfg(input bit a, input bit w);
        cfg_we = 1'b1; cfg_area_gap = a; cfg_wr_gap = w;
        @(negedge clk);
        cfg_we = 1'b0;
        en_a = a; en_w = w;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready && !bus_rd && !bus_wr && !bus_oe && !rsp_done, "R1 reset outputs",
            {req_ready, bus_rd, bus_wr, bus_oe, rsp_done}, 5'b10000);
        // Defaults: both rules active out of reset (R1)
        access(0, 12'h123, 8'h00, 0, "R1 first read");
        access(0, 12'h345, 8'h00, 1, "R1 area rule default");
        access(1, 12'h346, 8'h77, 1, "R1 write rule default");
        @(negedge clk);
        for (int c = 0; c < 4; c++) begin
            set_cfg(c[0], c[1]);
            for (int t = 0; t < 4; t++) begin
                for (int a = 0; a < 8; a++) begin
                    for (int b = 0; b < 8; b++) begin
                        bit w1, w2, g;
                        string tg;
                        logic [AW-1:0] ad1, ad2;
                        w1 = t[1]; w2 = t[0];
                        ad1 = {a[2:0], 9'(b * 37 + t)};
                        ad2 = {b[2:0], 9'(a * 53 + c)};
                        g = en_a && !w2 && (a != b) || en_w && w2;
                        g = g && !w1;
                        if (w1) tg = "R7";
                        else if (w2) tg = en_w ? "R6" : "R8";
                        else if (a == b) tg = "R5";
                        else tg = en_a ? "R4" : "R8";
                        @(negedge clk);
                        access(w1, ad1, 8'(a * 16 + b), 0, "R10 after idle spacer");
                        access(w2, ad2, 8'(b * 16 + a + c), g, tg);
                    end
                end
            end
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule